// File: doc/BRIEF.md
# TDMA scheduler control register file

This block is the host-facing configuration store for a time-division schedule engine. A host issues single-word accesses over a 32-bit port with word addresses counted from the block base. The block answers with an identifying header, a read-only pointer to the next block and a read-only count of timeslots. It also holds an enable bit for the engine and passes the engine's locked and error flags back to the host.

Four 128-bit time values set the schedule: the absolute start, the schedule period, the timeslot period and the active part of each timeslot. Each value is made of four 32-bit words, ordered from least to most significant: sub-nanosecond fraction, nanoseconds, lower seconds and upper seconds. The host writes the words into a staging copy, and it can read that copy back. The engine's copy changes only when the upper-seconds word is written. At that point all four words move across together, and a one-cycle update strobe for that value tells the engine to reload. A half-written value therefore never reaches the engine.

Top module: `tdma_cfg_regs`

## Requirements
- R1: A read of word 0 returns 0x0000C060 and a read of word 1 returns 0x00000100.
- R2: A read of word 2 returns the NEXT_PTR parameter and a read of word 3 returns the NUM_SLOTS parameter.
- R3: Word 4 bit 0 is the engine enable. A write sets `enable_o` to wdata bit 0 from the next cycle. A read returns the enable in bit 0 and zero in bits 31:1.
- R4: A read of word 5 returns `locked_i` in bit 0 and `error_i` in bit 1, with zero in all other bits.
- R5: Every accepted read produces exactly one response: `rsp_valid_o` is high for one cycle, the cycle after the request, and `rsp_rdata_o` holds the data. A write produces no response.
- R6: The time values sit at words 8–11 (start), 12–15 (schedule period), 16–19 (timeslot period) and 20–23 (active period). In each group, word offset k holds bits 32k+31:32k of the 128-bit value. A write to offset 0, 1 or 2 of a group changes neither the committed output nor `update_o`.
- R7: A read of any time-value word returns the staged word last written there.
- R8: A write to offset 3 of group p commits all four words: the three staged lower words plus the new upper word. The committed output shows the new value from the next cycle. In that same cycle `update_o[p]` is high, alone and for one cycle. Order: bit 0 = start, 1 = schedule period, 2 = timeslot period, 3 = active period.
- R9: Words 6, 7 and 24–31 read as zero. Writes to them, or to words 0–3 and 5, change no readable word and no output.
- R10: After reset, `enable_o`, `update_o`, every committed output and every staged word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address from block base |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| locked_i | input | 1 | Engine locked flag |
| error_i | input | 1 | Engine error flag |
| enable_o | output | 1 | Engine enable |
| start_time_o | output | 128 | Committed schedule start time |
| sched_period_o | output | 128 | Committed schedule period |
| slot_period_o | output | 128 | Committed timeslot period |
| active_period_o | output | 128 | Committed active period |
| update_o | output | 4 | One-cycle commit strobe per time value |

## Verification
The assertions take for granted that the host issues at most one access per cycle, so at most one commit strobe is high at a time. They also assume that every response comes from a read request in the cycle before. The bench holds each request for exactly one cycle, from one falling edge to the next, and it never overlaps a read with a write. The status flags change only between accesses. The update strobe and the committed outputs are sampled on the falling edge right after the write edge and again one cycle later. This covers the one-cycle width of the strobe as well as the hold-until-commit behaviour.

// File: rtl/tdma_cfg_pkg.sv
package tdma_cfg_pkg;
  localparam int DATA_W      = 32;
  localparam int PARAM_WORDS = 4;
  localparam int NUM_PARAMS  = 4;
  localparam int TIME_W      = DATA_W * PARAM_WORDS;

  localparam logic [DATA_W-1:0] TYPE_WORD = 32'h0000_C060;
  localparam logic [DATA_W-1:0] VER_WORD  = 32'h0000_0100;

  localparam int W_TYPE       = 0;
  localparam int W_VER        = 1;
  localparam int W_NEXT       = 2;
  localparam int W_SLOTS      = 3;
  localparam int W_CTRL       = 4;
  localparam int W_STAT       = 5;
  localparam int W_PARAM_BASE = 8;

  typedef enum logic [1:0] {
    P_START  = 2'd0,
    P_SCHED  = 2'd1,
    P_SLOT   = 2'd2,
    P_ACTIVE = 2'd3
  } param_e;
endpackage

// File: rtl/tdma_cfg_decode.sv
module tdma_cfg_decode
  import tdma_cfg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                              valid_i,
  input  logic                              write_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic                              rd_o,
  output logic                              ctrl_we_o,
  output logic [NUM_PARAMS*PARAM_WORDS-1:0] param_we_o
);
  localparam int N_WE = NUM_PARAMS * PARAM_WORDS;

  logic wr;
  assign wr        = valid_i && write_i;
  assign rd_o      = valid_i && !write_i;
  assign ctrl_we_o = wr && (addr_i == ADDR_W'(W_CTRL));

  for (genvar i = 0; i < N_WE; i++) begin : g_we
    assign param_we_o[i] = wr && (addr_i == ADDR_W'(W_PARAM_BASE + i));
  end
endmodule

// File: rtl/tdma_ctrl_reg.sv
module tdma_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wbit_i,
  output logic enable_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (we_i) en_q <= wbit_i;
  end

  assign enable_o = en_q;

  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(enable_o));
endmodule

// File: rtl/tdma_time_param.sv
module tdma_time_param #(
  parameter int DW = 32,
  parameter int NW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NW-1:0]  we_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [NW*DW-1:0] stage_o,
  output logic [NW*DW-1:0] commit_o,
  output logic           upd_o
);
  localparam int LO_W = (NW - 1) * DW;

  logic [NW*DW-1:0] stage_q, commit_q;
  logic             upd_q;

  for (genvar w = 0; w < NW; w++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[w*DW +: DW] <= '0;
      else if (we_i[w]) stage_q[w*DW +: DW] <= wdata_i;
    end
  end

  // whole value moves on the top-word write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= '0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= we_i[NW-1];
      if (we_i[NW-1]) commit_q <= {wdata_i, stage_q[LO_W-1:0]};
    end
  end

  assign stage_o  = stage_q;
  assign commit_o = commit_q;
  assign upd_o    = upd_q;

  // R6
  commit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(commit_o));
  // R8
  commit_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> commit_o[NW*DW-1 -: DW] == $past(wdata_i));
  // R8
  commit_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> commit_o[LO_W-1:0] == $past(stage_o[LO_W-1:0]));
endmodule

// File: rtl/tdma_cfg_regs.sv
module tdma_cfg_regs
  import tdma_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter logic [31:0]     NEXT_PTR  = 32'h0,
  parameter int              NUM_SLOTS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic              locked_i,
  input  logic              error_i,
  output logic              enable_o,
  output logic [127:0]      start_time_o,
  output logic [127:0]      sched_period_o,
  output logic [127:0]      slot_period_o,
  output logic [127:0]      active_period_o,
  output logic [3:0]        update_o
);
  localparam int N_WE = NUM_PARAMS * PARAM_WORDS;

  logic                rd;
  logic                ctrl_we;
  logic [N_WE-1:0]     param_we;
  logic [TIME_W-1:0]   stage  [NUM_PARAMS];
  logic [TIME_W-1:0]   commit [NUM_PARAMS];
  logic [NUM_PARAMS-1:0] upd;
  logic [DATA_W-1:0]   rd_data;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;

  assign req_ready_o = 1'b1;

  tdma_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .addr_i     (req_addr_i),
    .rd_o       (rd),
    .ctrl_we_o  (ctrl_we),
    .param_we_o (param_we)
  );

  tdma_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we),
    .wbit_i   (req_wdata_i[0]),
    .enable_o (enable_o)
  );

  for (genvar p = 0; p < NUM_PARAMS; p++) begin : g_param
    tdma_time_param #(.DW(DATA_W), .NW(PARAM_WORDS)) u_param (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (param_we[p*PARAM_WORDS +: PARAM_WORDS]),
      .wdata_i  (req_wdata_i),
      .stage_o  (stage[p]),
      .commit_o (commit[p]),
      .upd_o    (upd[p])
    );
  end

  assign start_time_o    = commit[P_START];
  assign sched_period_o  = commit[P_SCHED];
  assign slot_period_o   = commit[P_SLOT];
  assign active_period_o = commit[P_ACTIVE];
  assign update_o        = upd;

  always_comb begin
    rd_data = '0;
    case (req_addr_i)
      ADDR_W'(W_TYPE):  rd_data = TYPE_WORD;
      ADDR_W'(W_VER):   rd_data = VER_WORD;
      ADDR_W'(W_NEXT):  rd_data = NEXT_PTR;
      ADDR_W'(W_SLOTS): rd_data = DATA_W'(NUM_SLOTS);
      ADDR_W'(W_CTRL):  rd_data = {{(DATA_W-1){1'b0}}, enable_o};
      ADDR_W'(W_STAT):  rd_data = {{(DATA_W-2){1'b0}}, error_i, locked_i};
      default: begin
        for (int p = 0; p < NUM_PARAMS; p++) begin
          for (int w = 0; w < PARAM_WORDS; w++) begin
            if (req_addr_i == ADDR_W'(W_PARAM_BASE + p*PARAM_WORDS + w))
              rd_data = stage[p][w*DATA_W +: DATA_W];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd;
      if (rd) rsp_rdata_q <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  // R5
  rsp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));
  // R5
  rsp_given_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  // R8
  one_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(update_o));
endmodule

// File: tb/tdma_cfg_regs_tb_top.sv
module tdma_cfg_regs_tb_top;
  localparam int          AW     = 5;
  localparam logic [31:0] NPTR   = 32'h0000_0400;
  localparam int          SLOTS  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          locked = 1'b0, error = 1'b0;
  logic          enable;
  logic [127:0]  t_start, t_sched, t_slot, t_active;
  logic [3:0]    update;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  tdma_cfg_regs #(.ADDR_W(AW), .NEXT_PTR(NPTR), .NUM_SLOTS(SLOTS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .locked_i(locked), .error_i(error), .enable_o(enable),
    .start_time_o(t_start), .sched_period_o(t_sched),
    .slot_period_o(t_slot), .active_period_o(t_active),
    .update_o(update)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expectation on each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R5: actual unexpected response %h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {96'd0, rsp_rdata}, {96'd0, e});
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [127:0] committed(int p);
    case (p)
      0: return t_start;
      1: return t_sched;
      2: return t_slot;
      default: return t_active;
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  logic [127:0] model [4];

  initial begin
    for (int p = 0; p < 4; p++) model[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10 enable", {127'd0, enable}, 128'd0);
    chk("R10 update", {124'd0, update}, 128'd0);
    for (int p = 0; p < 4; p++) chk("R10 committed", committed(p), 128'd0);
    rd(8, 32'h0, "R10 staged start");
    rd(23, 32'h0, "R10 staged active hi");
    // R1, R2
    rd(0, 32'h0000_C060, "R1 type");
    rd(1, 32'h0000_0100, "R1 version");
    rd(2, NPTR, "R2 next");
    rd(3, 32'(SLOTS), "R2 slots");
    // R3
    wr(4, 32'hFFFF_FFFF);
    chk("R3 enable on", {127'd0, enable}, 128'd1);
    chk("R5 no write rsp", {127'd0, rsp_valid}, 128'd0);
    rd(4, 32'h1, "R3 ctrl read");
    wr(4, 32'hFFFF_FFFE);
    chk("R3 enable off", {127'd0, enable}, 128'd0);
    rd(4, 32'h0, "R3 ctrl read off");
    // R4
    locked = 1'b1; error = 1'b0;
    rd(5, 32'h1, "R4 locked");
    locked = 1'b0; error = 1'b1;
    rd(5, 32'h2, "R4 error");
    locked = 1'b1;
    rd(5, 32'h3, "R4 both");
    // R9
    wr(0, 32'h1234_5678);
    wr(3, 32'h0);
    wr(5, 32'hFFFF_FFFF);
    wr(6, 32'hDEAD_BEEF);
    wr(27, 32'hDEAD_BEEF);
    rd(0, 32'h0000_C060, "R9 type after write");
    rd(3, 32'(SLOTS), "R9 slots after write");
    rd(6, 32'h0, "R9 word6");
    rd(7, 32'h0, "R9 word7");
    rd(27, 32'h0, "R9 word27");
    rd(31, 32'h0, "R9 word31");
    chk("R9 enable", {127'd0, enable}, 128'd0);
    chk("R9 update", {124'd0, update}, 128'd0);
    // R6 R7 R8 per value
    for (int p = 0; p < 4; p++) begin
      automatic logic [127:0] v = {32'hA000_0000 + 32'(p), 32'h0B00_0000 + 32'(p),
                                   32'h00C0_0000 + 32'(p), 32'h000D_0000 + 32'(p)};
      for (int w = 0; w < 3; w++) begin
        wr(8 + 4*p + w, v[w*32 +: 32]);
        chk("R6 no update", {124'd0, update}, 128'd0);
        for (int q = 0; q < 4; q++) chk("R6 committed held", committed(q), model[q]);
      end
      for (int w = 0; w < 3; w++) rd(8 + 4*p + w, v[w*32 +: 32], "R7 staged readback");
      wr(8 + 4*p + 3, v[127:96]);
      model[p] = v;
      chk("R8 update pulse", {124'd0, update}, 128'(4'b0001 << p));
      for (int q = 0; q < 4; q++) chk("R8 committed", committed(q), model[q]);
      @(negedge clk);
      chk("R8 pulse one cycle", {124'd0, update}, 128'd0);
      rd(8 + 4*p + 3, v[127:96], "R7 staged hi readback");
    end
    // R8 partial restage: only fraction word changes
    wr(9 * 1 + 7, 32'h5555_5555);
    rd(16, 32'h5555_5555, "R7 slot frac restaged");
    chk("R6 slot held", t_slot, model[2]);
    wr(19, 32'h7777_7777);
    model[2] = {32'h7777_7777, model[2][95:32], 32'h5555_5555};
    chk("R8 slot partial commit", t_slot, model[2]);
    chk("R8 slot pulse", {124'd0, update}, 128'd4);
    repeat (3) @(negedge clk);
    chk("R5 queue drained", 128'(exp_q.size()), 128'd0);
    done = 1'b1;
    finish_run();
  end
endmodule